// File: doc/BRIEF.md
# VLIW Packet Commit Logger

This block holds every side effect that one instruction packet produces until the packet is committed. General register results, predicate results, at most one store per memory slot (slot 0 and slot 1) and a taken-branch target are captured while the packet executes. A packet-start pulse opens a fresh packet. A commit pulse drains the held stores to a 64-bit memory write port that has a valid/ready handshake and byte enables. The buffered register, predicate and branch results are visible on output buses for the surrounding pipeline to consume when the done pulse appears.

Several rules decide how overlapping effects combine. Repeated writes to one predicate inside a packet are merged with a bitwise AND. The first taken branch of a packet decides the next PC. An execute stage can cancel a slot through a cancel mask, and a cancelled store never reaches memory. A load issued from slot 0 is held back while an uncancelled slot-1 store is pending. That store is pushed to memory at once, and the load is released only after the store has been accepted.

Top module: `pkt_commit_log`

## Requirements
- R1: After reset the register mask, predicate mask, branch-taken flag, width error flag, memory valid and done pulse are all 0.
- R2: A register write sets bit `gw_idx` of `gpr_mask` and places the data in lane `gw_idx` of `gpr_vals` (GPR_W bits per lane) on the next cycle. A later write to the same index in the packet replaces the value.
- R3: Predicate values are 8 bits and lane k of `pred_vals` is bits [8k+7:8k]. Only bits [7:0] of `pw_data` are used. The first write to a predicate in a packet loads those bits and sets its `pred_mask` bit. Each further write ANDs its bits into the held value.
- R4: The first asserted `br_en` in a packet sets `br_taken` and loads `next_pc`. Later branch requests in the same packet leave `next_pc` unchanged.
- R5: `pkt_start` clears the register and predicate masks and values, `br_taken`, `next_pc`, the cancel mask, held stores and `width_err`. Writes presented in the same cycle as `pkt_start` belong to the new packet.
- R6: A store's size code `st_size` counts bytes: 1, 2, 4 or 8. `mem_addr` is the store address with bits [2:0] cleared. The address is aligned down to the access size, and `mem_be` enables that many bytes starting at the aligned byte offset (bit i enables byte lane i).
- R7: `mem_wdata` carries the low bytes of the store data shifted into the enabled lanes; disabled lanes are 0.
- R8: A store whose size code is not 1, 2, 4 or 8 is dropped and sets `width_err` until the next `pkt_start`.
- R9: On `commit` the pending stores are issued in slot order 0 then 1. Each request holds its address, enables and data until `mem_ready` is seen.
- R10: A store whose slot bit was set through `cancel_set` before it is issued is never issued.
- R11: `commit_done` pulses for one cycle once no issuable store remains after a commit, including a commit with no stores.
- R12: While `ld_req` is high from slot 0 (`ld_slot`=0) and an uncancelled slot-1 store is held, `ld_go` is 0 and that store is issued. `ld_go` rises once it has been accepted, and the store is not issued again at commit.
- R13: A load from slot 1, or a slot-0 load with no issuable slot-1 store, gets `ld_go` in the same cycle as `ld_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Opens a new packet |
| commit | input | 1 | Starts draining held stores |
| gw_en | input | 1 | Register write request |
| gw_idx | input | GIDX_W | Register index |
| gw_data | input | GPR_W | Register value |
| pw_en | input | 1 | Predicate write request |
| pw_idx | input | PIDX_W | Predicate index |
| pw_data | input | PW_REQ_W | Predicate request value; low 8 bits kept |
| br_en | input | 1 | Taken-branch request |
| br_target | input | ADDR_W | Branch target |
| st_en | input | 1 | Store request |
| st_slot | input | 1 | Store slot |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 4 | Store size in bytes |
| st_data | input | 64 | Store data, low bytes used |
| cancel_set | input | 2 | Slot cancel bits, ORed into the mask |
| ld_req | input | 1 | Load request |
| ld_slot | input | 1 | Load slot |
| ld_go | output | 1 | Load may read memory |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | 8-byte aligned write address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_ready | input | 1 | Memory accepts request |
| gpr_mask | output | NUM_GPR | Registers written in packet |
| gpr_vals | output | NUM_GPR*GPR_W | Buffered register values |
| pred_mask | output | NUM_PRED | Predicates written in packet |
| pred_vals | output | NUM_PRED*8 | Merged predicate values |
| br_taken | output | 1 | A branch was taken |
| next_pc | output | ADDR_W | First taken branch target |
| width_err | output | 1 | Illegal store size seen |
| commit_done | output | 1 | Commit finished pulse |

## Verification
Two pairs of functions can land in one cycle. A predicate write can arrive together with `pkt_start`, which could merge into the stale value. A slot-0 load can arrive while a slot-1 store is held, so that store competes with the later commit drain. The bench holds a predicate from an old packet, then presents a new write in the `pkt_start` cycle, and expects the new value alone rather than an AND with the old one. It raises a slot-0 load against a held slot-1 store while `mem_ready` stalls. It then judges that `ld_go` stays low until exactly one memory transaction with the slot-1 address is logged, and that the following commit issues nothing more.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    localparam int LANE_N = 8;
    localparam int BUS_W  = 8 * LANE_N;
    localparam int SIZE_W = 4;

    typedef enum logic [0:0] {
        DR_IDLE   = 1'b0,
        DR_COMMIT = 1'b1
    } drain_e;

    function automatic logic size_ok(input logic [SIZE_W-1:0] s);
        return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
    endfunction
endpackage

// File: rtl/pcl_lane_map.sv
module pcl_lane_map
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [ADDR_W-1:0] line_addr_o,
    output logic [LANE_N-1:0] be_o,
    output logic [BUS_W-1:0]  wdata_o
);
    logic [2:0]        off;
    logic [LANE_N-1:0] base_mask;
    logic [BUS_W-1:0]  shifted;

    always_comb begin
        case (size_i)
            4'd1: begin off = addr_i[2:0];          base_mask = 8'h01; end
            4'd2: begin off = {addr_i[2:1], 1'b0};  base_mask = 8'h03; end
            4'd4: begin off = {addr_i[2], 2'b00};   base_mask = 8'h0F; end
            default: begin off = 3'd0;              base_mask = 8'hFF; end
        endcase
        be_o        = base_mask << off;
        shifted     = data_i << {off, 3'b000};
        line_addr_o = {addr_i[ADDR_W-1:3], 3'b000};
    end

    generate
        for (genvar i = 0; i < LANE_N; i++) begin : g_lane
            assign wdata_o[8*i +: 8] = be_o[i] ? shifted[8*i +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/pcl_slot.sv
module pcl_slot
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [BUS_W-1:0]  data_i,
    input  logic              retire_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [BUS_W-1:0]  data_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [BUS_W-1:0]  data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (retire_i || clear_i) begin
            s_d.vld = 1'b0;
        end
        if (load_i) begin
            s_d.vld  = 1'b1;
            s_d.addr = addr_i;
            s_d.size = size_i;
            s_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o  = s_q.vld;
    assign addr_o = s_q.addr;
    assign size_o = s_q.size;
    assign data_o = s_q.data;
endmodule

// File: rtl/pcl_pred_buf.sv
module pcl_pred_buf #(
    parameter int NUM_PRED = 4,
    parameter int PRED_W   = 8,
    localparam int PIDX_W  = $clog2(NUM_PRED)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       wr_i,
    input  logic [PIDX_W-1:0]          idx_i,
    input  logic [PRED_W-1:0]          data_i,
    output logic [NUM_PRED-1:0]        seen_o,
    output logic [NUM_PRED*PRED_W-1:0] vals_o
);
    typedef struct packed {
        logic [NUM_PRED-1:0]        seen;
        logic [NUM_PRED*PRED_W-1:0] val;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clear_i) begin
            pb_d = '0;
        end
        if (wr_i) begin
            if (pb_d.seen[idx_i]) begin
                pb_d.val[idx_i*PRED_W +: PRED_W] = pb_d.val[idx_i*PRED_W +: PRED_W] & data_i;
            end else begin
                pb_d.val[idx_i*PRED_W +: PRED_W] = data_i;
                pb_d.seen[idx_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign seen_o = pb_q.seen;
    assign vals_o = pb_q.val;
endmodule

// File: rtl/pkt_commit_log.sv
module pkt_commit_log
    import pcl_pkg::*;
#(
    parameter int NUM_GPR  = 8,
    parameter int GPR_W    = 32,
    parameter int NUM_PRED = 4,
    parameter int PRED_W   = 8,
    parameter int PW_REQ_W = 32,
    parameter int ADDR_W   = 32,
    localparam int GIDX_W  = $clog2(NUM_GPR),
    localparam int PIDX_W  = $clog2(NUM_PRED)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pkt_start,
    input  logic                       commit,
    input  logic                       gw_en,
    input  logic [GIDX_W-1:0]          gw_idx,
    input  logic [GPR_W-1:0]           gw_data,
    input  logic                       pw_en,
    input  logic [PIDX_W-1:0]          pw_idx,
    input  logic [PW_REQ_W-1:0]        pw_data,
    input  logic                       br_en,
    input  logic [ADDR_W-1:0]          br_target,
    input  logic                       st_en,
    input  logic                       st_slot,
    input  logic [ADDR_W-1:0]          st_addr,
    input  logic [3:0]                 st_size,
    input  logic [63:0]                st_data,
    input  logic [1:0]                 cancel_set,
    input  logic                       ld_req,
    input  logic                       ld_slot,
    output logic                       ld_go,
    output logic                       mem_valid,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [7:0]                 mem_be,
    output logic [63:0]                mem_wdata,
    input  logic                       mem_ready,
    output logic [NUM_GPR-1:0]         gpr_mask,
    output logic [NUM_GPR*GPR_W-1:0]   gpr_vals,
    output logic [NUM_PRED-1:0]        pred_mask,
    output logic [NUM_PRED*PRED_W-1:0] pred_vals,
    output logic                       br_taken,
    output logic [ADDR_W-1:0]          next_pc,
    output logic                       width_err,
    output logic                       commit_done
);
    localparam int NUM_SLOT = 2;

    typedef struct packed {
        logic [NUM_GPR-1:0]       gmask;
        logic [NUM_GPR*GPR_W-1:0] gval;
        logic                     br;
        logic [ADDR_W-1:0]        pc;
        logic [NUM_SLOT-1:0]      cxl;
        logic                     werr;
        drain_e                   st;
        logic                     done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_SLOT-1:0] s_vld, s_load, s_retire, pend;
    logic [ADDR_W-1:0]   s_addr [NUM_SLOT];
    logic [SIZE_W-1:0]   s_size [NUM_SLOT];
    logic [BUS_W-1:0]    s_data [NUM_SLOT];
    logic                sel;
    logic                req;
    logic                early;
    logic                st_legal;
    logic                pw_unused_hi;

    assign st_legal     = st_en & size_ok(st_size);
    assign pw_unused_hi = ^pw_data[PW_REQ_W-1:PRED_W];

    // Store slots, one per memory slot
    generate
        for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
            assign s_load[g]   = st_legal & (st_slot == 1'(g));
            assign pend[g]     = s_vld[g] & ~c_q.cxl[g];
            assign s_retire[g] = mem_valid & mem_ready & (sel == 1'(g));

            pcl_slot #(.ADDR_W(ADDR_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear_i  (pkt_start),
                .load_i   (s_load[g]),
                .addr_i   (st_addr),
                .size_i   (st_size),
                .data_i   (st_data),
                .retire_i (s_retire[g]),
                .vld_o    (s_vld[g]),
                .addr_o   (s_addr[g]),
                .size_o   (s_size[g]),
                .data_o   (s_data[g])
            );
        end
    endgenerate

    // Predicate merge buffer
    pcl_pred_buf #(.NUM_PRED(NUM_PRED), .PRED_W(PRED_W)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pkt_start),
        .wr_i    (pw_en),
        .idx_i   (pw_idx),
        .data_i  (pw_data[PRED_W-1:0]),
        .seen_o  (pred_mask),
        .vals_o  (pred_vals)
    );

    // Memory request source: commit drain in slot order, or early slot-1 drain
    always_comb begin
        early = (c_q.st == DR_IDLE) & ld_req & (ld_slot == 1'b0) & pend[1];
        if (c_q.st == DR_COMMIT) begin
            req = |pend;
            sel = pend[0] ? 1'b0 : 1'b1;
        end else begin
            req = early;
            sel = 1'b1;
        end
    end

    assign mem_valid = req;
    assign ld_go     = ld_req & ~((ld_slot == 1'b0) & pend[1]);

    pcl_lane_map #(.ADDR_W(ADDR_W)) u_lane (
        .addr_i      (s_addr[sel]),
        .size_i      (s_size[sel]),
        .data_i      (s_data[sel]),
        .line_addr_o (mem_addr),
        .be_o        (mem_be),
        .wdata_o     (mem_wdata)
    );

    // Packet bookkeeping and drain sequencing
    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (pkt_start) begin
            c_d.gmask = '0;
            c_d.gval  = '0;
            c_d.br    = 1'b0;
            c_d.pc    = '0;
            c_d.cxl   = '0;
            c_d.werr  = 1'b0;
        end
        if (gw_en) begin
            c_d.gval[gw_idx*GPR_W +: GPR_W] = gw_data;
            c_d.gmask[gw_idx] = 1'b1;
        end
        if (br_en && !c_d.br) begin
            c_d.br = 1'b1;
            c_d.pc = br_target;
        end
        c_d.cxl = c_d.cxl | cancel_set;
        if (st_en && !size_ok(st_size)) begin
            c_d.werr = 1'b1;
        end
        case (c_q.st)
            DR_IDLE: begin
                if (commit) begin
                    c_d.st = DR_COMMIT;
                end
            end
            DR_COMMIT: begin
                if (!(|pend)) begin
                    c_d.st   = DR_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign gpr_mask    = c_q.gmask;
    assign gpr_vals    = c_q.gval;
    assign br_taken    = c_q.br;
    assign next_pc     = c_q.pc;
    assign width_err   = c_q.werr;
    assign commit_done = c_q.done;
endmodule

// File: rtl/pcl_checks.sv
module pcl_checks #(
    parameter int NUM_PRED = 4,
    parameter int PRED_W   = 8,
    parameter int PW_REQ_W = 32,
    parameter int ADDR_W   = 32,
    localparam int PIDX_W  = $clog2(NUM_PRED)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pkt_start,
    input logic                       pw_en,
    input logic [PIDX_W-1:0]          pw_idx,
    input logic [PW_REQ_W-1:0]        pw_data,
    input logic [NUM_PRED-1:0]        pred_mask,
    input logic [NUM_PRED*PRED_W-1:0] pred_vals,
    input logic                       br_taken,
    input logic [ADDR_W-1:0]          next_pc,
    input logic                       mem_valid,
    input logic                       mem_ready,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [7:0]                 mem_be,
    input logic [1:0]                 cancel_set,
    input logic                       ld_req,
    input logic                       commit_done,
    input logic                       st_en,
    input logic [3:0]                 st_size,
    input logic                       width_err
);
    logic [PRED_W-1:0] cur_sel;
    logic [PRED_W-1:0] and_exp;
    logic [PIDX_W-1:0] idx_q;
    logic              bad_size;

    assign cur_sel  = pred_vals[pw_idx*PRED_W +: PRED_W];
    assign and_exp  = cur_sel & pw_data[PRED_W-1:0];
    assign bad_size = !((st_size == 4'd1) || (st_size == 4'd2) ||
                        (st_size == 4'd4) || (st_size == 4'd8));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= pw_idx;
        end
    end

    a_r3_pred_and: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && !pkt_start && pred_mask[pw_idx]) |=>
            (pred_vals[idx_q*PRED_W +: PRED_W] == $past(and_exp)));

    a_r4_first_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !pkt_start) |=> (br_taken && $stable(next_pc)));

    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !pkt_start && cancel_set == 2'b00 && !ld_req) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_be)));

    a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (($countones(mem_be) == 1) || ($countones(mem_be) == 2) ||
                       ($countones(mem_be) == 4) || ($countones(mem_be) == 8)));

    a_r8_width_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && bad_size) |=> width_err);

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_done && !ld_req) |-> !mem_valid);
endmodule

bind pkt_commit_log pcl_checks #(
    .NUM_PRED (NUM_PRED),
    .PRED_W   (PRED_W),
    .PW_REQ_W (PW_REQ_W),
    .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/sim_pkt_commit_log.sv
module sim_pkt_commit_log;
    localparam int NUM_GPR = 8;
    localparam int GPR_W   = 32;
    localparam int NUM_PRED = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_start = 0, commit = 0;
    logic gw_en = 0; logic [2:0] gw_idx = 0; logic [31:0] gw_data = 0;
    logic pw_en = 0; logic [1:0] pw_idx = 0; logic [31:0] pw_data = 0;
    logic br_en = 0; logic [31:0] br_target = 0;
    logic st_en = 0, st_slot = 0; logic [31:0] st_addr = 0; logic [3:0] st_size = 0;
    logic [63:0] st_data = 0;
    logic [1:0] cancel_set = 0;
    logic ld_req = 0, ld_slot = 0, ld_go;
    logic mem_valid; logic [31:0] mem_addr; logic [7:0] mem_be; logic [63:0] mem_wdata;
    logic mem_ready = 1'b1;
    logic [NUM_GPR-1:0] gpr_mask; logic [NUM_GPR*GPR_W-1:0] gpr_vals;
    logic [NUM_PRED-1:0] pred_mask; logic [NUM_PRED*8-1:0] pred_vals;
    logic br_taken; logic [31:0] next_pc; logic width_err, commit_done;

    int n_chk = 0, n_err = 0;
    int rdy_cnt = 0;
    int txn_n = 0;
    logic [31:0] txn_addr [16];
    logic [7:0]  txn_be   [16];
    logic [63:0] txn_data [16];

    always #10 clk = ~clk;

    pkt_commit_log u0 (.*);

    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        mem_ready <= (rdy_cnt % 3) != 1;
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready && txn_n < 16) begin
            txn_addr[txn_n] = mem_addr;
            txn_be[txn_n]   = mem_be;
            txn_data[txn_n] = mem_wdata;
            txn_n = txn_n + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] be_of(input logic [31:0] a, input int sz);
        case (sz)
            1: return 8'h01 << a[2:0];
            2: return 8'h03 << {a[2:1], 1'b0};
            4: return 8'h0F << {a[2], 2'b00};
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] data_of(input logic [7:0] be, input logic [63:0] d);
        logic [63:0] r = '0;
        int off = 0;
        for (int i = 7; i >= 0; i--) if (be[i]) off = i;
        for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = d[8*(i-off) +: 8];
        return r;
    endfunction

    task automatic new_pkt();
        @(negedge clk); pkt_start = 1;
        @(negedge clk); pkt_start = 0;
        txn_n = 0;
    endtask

    task automatic put_pred(input int idx, input logic [31:0] v);
        @(negedge clk); pw_en = 1; pw_idx = 2'(idx); pw_data = v;
        @(negedge clk); pw_en = 0;
    endtask

    task automatic put_store(input bit slot, input logic [31:0] a, input int sz, input logic [63:0] d);
        @(negedge clk); st_en = 1; st_slot = slot; st_addr = a; st_size = 4'(sz); st_data = d;
        @(negedge clk); st_en = 0;
    endtask

    task automatic run_commit(output bit got);
        got = 0;
        @(negedge clk); commit = 1;
        @(negedge clk); commit = 0;
        for (int i = 0; i < 100 && !got; i++) begin
            if (commit_done) got = 1; else @(negedge clk);
        end
    endtask

    initial begin
        bit got;
        logic [7:0] v1, v2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(gpr_mask == 0 && pred_mask == 0, "R1 masks", {gpr_mask, pred_mask}, 0);
        check(!br_taken && !width_err && !mem_valid && !commit_done, "R1 flags",
              {br_taken, width_err, mem_valid, commit_done}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 register buffering, last write wins
        new_pkt();
        @(negedge clk); gw_en = 1; gw_idx = 3; gw_data = 32'h1111_2222;
        @(negedge clk); gw_idx = 3; gw_data = 32'hCAFE_0003;
        @(negedge clk); gw_idx = 5; gw_data = 32'h5555_AAAA;
        @(negedge clk); gw_en = 0;
        check(gpr_mask == 8'h28, "R2 mask", gpr_mask, 8'h28);
        check(gpr_vals[3*32 +: 32] == 32'hCAFE_0003, "R2 replace", gpr_vals[3*32 +: 32], 32'hCAFE_0003);
        check(gpr_vals[5*32 +: 32] == 32'h5555_AAAA, "R2 value", gpr_vals[5*32 +: 32], 32'h5555_AAAA);

        // R3 predicate first load and AND merge, swept over index and values
        for (int p = 0; p < NUM_PRED; p++) begin
            for (int k = 0; k < 4; k++) begin
                v1 = 8'(8'hA5 ^ (p * 37 + k * 11));
                v2 = 8'(8'h3C + p * 5 + k * 29);
                new_pkt();
                put_pred(p, {24'hFFFFFF, v1});
                check(pred_vals[8*p +: 8] == v1 && pred_mask == 4'(1 << p), "R3 first",
                      {pred_mask, pred_vals[8*p +: 8]}, {4'(1 << p), v1});
                put_pred(p, {24'h123456, v2});
                check(pred_vals[8*p +: 8] == (v1 & v2), "R3 and", pred_vals[8*p +: 8], v1 & v2);
            end
        end

        // R4 first branch wins
        new_pkt();
        @(negedge clk); br_en = 1; br_target = 32'h0000_4000;
        @(negedge clk); br_target = 32'h0000_8000;
        @(negedge clk); br_en = 0;
        check(br_taken && next_pc == 32'h4000, "R4 first", next_pc, 32'h4000);

        // R5 start with same-cycle writes belongs to new packet
        put_pred(2, 32'h0F);
        @(negedge clk); pkt_start = 1; pw_en = 1; pw_idx = 2; pw_data = 32'hF3;
        br_en = 1; br_target = 32'h9000; txn_n = 0;
        @(negedge clk); pkt_start = 0; pw_en = 0; br_en = 0;
        check(pred_vals[16 +: 8] == 8'hF3 && pred_mask == 4'b0100, "R5 pred fresh",
              {pred_mask, pred_vals[16 +: 8]}, {4'b0100, 8'hF3});
        check(next_pc == 32'h9000 && gpr_mask == 0, "R5 clear", {gpr_mask, next_pc}, 32'h9000);

        // R6 R7 R9 R11 store sweep over sizes and offsets
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 8; o++) begin
                int sz = 1 << s;
                logic [31:0] a = 32'h0000_1000 + 32'(s * 64) + 32'(o);
                logic [63:0] d = {32'h1357_9BDF ^ 32'(o), 32'h0246_8ACE + 32'(s)};
                logic [7:0] eb = be_of(a, sz);
                new_pkt();
                put_store(0, a, sz, d);
                run_commit(got);
                check(got && txn_n == 1, "R11 done one txn", txn_n, 1);
                check(txn_addr[0] == {a[31:3], 3'b000} && txn_be[0] == eb, "R6 addr/be",
                      {txn_addr[0], 24'h0, txn_be[0]}, {a[31:3], 3'b000, 24'h0, eb});
                check(txn_data[0] == data_of(eb, d), "R7 data", txn_data[0], data_of(eb, d));
            end
        end

        // R9 slot order
        new_pkt();
        put_store(1, 32'h2008, 4, 64'h1);
        put_store(0, 32'h3010, 8, 64'h2);
        run_commit(got);
        check(got && txn_n == 2, "R9 count", txn_n, 2);
        check(txn_addr[0] == 32'h3010 && txn_addr[1] == 32'h2008, "R9 order",
              {txn_addr[0], txn_addr[1]}, {32'h3010, 32'h2008});

        // R10 cancel one, then both
        new_pkt();
        put_store(0, 32'h4000, 2, 64'h3);
        put_store(1, 32'h5000, 2, 64'h4);
        @(negedge clk); cancel_set = 2'b01;
        @(negedge clk); cancel_set = 2'b00;
        run_commit(got);
        check(txn_n == 1 && txn_addr[0] == 32'h5000, "R10 cancel slot0", txn_addr[0], 32'h5000);
        new_pkt();
        put_store(0, 32'h4000, 2, 64'h3);
        put_store(1, 32'h5000, 2, 64'h4);
        @(negedge clk); cancel_set = 2'b11;
        @(negedge clk); cancel_set = 2'b00;
        run_commit(got);
        check(got && txn_n == 0, "R10 R11 none issued", txn_n, 0);

        // R8 illegal sizes sweep
        for (int z = 0; z < 16; z++) begin
            if (z != 1 && z != 2 && z != 4 && z != 8) begin
                new_pkt();
                put_store(0, 32'h6000, z, 64'hFF);
                check(width_err == 1'b1, "R8 flag", width_err, 1);
                run_commit(got);
                check(txn_n == 0, "R8 dropped", txn_n, 0);
            end
        end
        new_pkt();
        check(width_err == 1'b0, "R5 werr clear", width_err, 0);

        // R12 early drain of slot-1 store for a slot-0 load
        new_pkt();
        put_store(1, 32'h7004, 4, 64'hDEAD_BEEF);
        @(negedge clk); ld_req = 1; ld_slot = 0;
        #1;
        check(ld_go == 1'b0, "R12 load held", ld_go, 0);
        got = 0;
        for (int i = 0; i < 50 && !got; i++) begin
            @(negedge clk); #1;
            if (ld_go) got = 1;
        end
        check(got && txn_n == 1 && txn_addr[0] == 32'h7000, "R12 drained first",
              {txn_n, txn_addr[0]}, {32'd1, 32'h7000});
        @(negedge clk); ld_req = 0;
        run_commit(got);
        check(txn_n == 1, "R12 not reissued", txn_n, 1);

        // R13 slot-1 load and cancelled slot-1 store pass at once
        new_pkt();
        put_store(1, 32'h7100, 4, 64'h5);
        @(negedge clk); ld_req = 1; ld_slot = 1;
        #1;
        check(ld_go == 1'b1, "R13 slot1 load", ld_go, 1);
        @(negedge clk); ld_req = 0; cancel_set = 2'b10;
        @(negedge clk); cancel_set = 2'b00; ld_req = 1; ld_slot = 0;
        #1;
        check(ld_go == 1'b1 && txn_n == 0, "R13 cancelled store", {ld_go, txn_n}, 1 << 32);
        @(negedge clk); ld_req = 0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule